// File: doc/BRIEF.md
# Aliased-Window Semaphore Bank

This block holds an array of 32-bit semaphores behind a single-cycle APB-style register port. The array appears at several address windows, and the window an access uses picks the operation. One window only reads. One overwrites the semaphore with the write data. One adds one, and one subtracts one; on these two windows the write data is ignored. A build option adds a further window that adds the write data to the semaphore.

Every read-modify-write finishes in the cycle of the access. Increments saturate at the top of the 32-bit range and latch a sticky overflow interrupt. Software clears that interrupt through a status register. Decrements stop at zero.

The same block also runs a free-running timestamp. It advances every clock by a programmable 24-bit step, so a group of engines can share one time base. The lowest kilobyte of the space is reserved for event storage, which is kept elsewhere. The bank answers it quietly.

Top module: `sem_bank`

## Requirements
- R1: After reset every semaphore reads 0, the overflow interrupt is low, the status register at offset 0x804 reads 0, the step register at offset 0x800 reads 0x400, and the timestamp is 0.
- R2: A write to 0x1400 + 4·N stores the write data in semaphore N. A later read at 0x1000 + 4·N returns that value.
- R3: A write to 0x1800 + 4·N adds one to semaphore N and ignores the write data. If the semaphore already holds 0xFFFFFFFF, it stays at 0xFFFFFFFF and the overflow interrupt is set. The interrupt then stays set until software clears it.
- R4: A write to 0x1C00 + 4·N subtracts one from semaphore N and ignores the write data. A semaphore at 0 stays at 0 and no overflow is raised.
- R5: A read through any semaphore window returns the current value of semaphore N. A write to the read window (0x1000) changes nothing.
- R6: When HAS_CNTR_WIN is 1, a write to 0x2000 + 4·N adds the write data to semaphore N. A sum that passes 0xFFFFFFFF saturates to 0xFFFFFFFF and sets the overflow interrupt. When HAS_CNTR_WIN is 0, that window is unmapped.
- R7: Each access takes one setup cycle and one access cycle, and pready is always high. An access that directly follows an update of the same semaphore sees the updated value.
- R8: Bit 0 of the status register at 0x804 mirrors the overflow interrupt. Writing a 1 to bit 0 clears the interrupt. Writing a 0 leaves it unchanged.
- R9: The timestamp increases by the step register every clock. The step register at 0x800 keeps only write data bits 23:0, and a new step applies from the clock after the write.
- R10: These accesses read as 0, assert pslverr, and change no state: an index N at or above NUM_SEM in any semaphore window, any offset in 0x400–0xFFF other than 0x800 and 0x804, any offset at or above the last window, and any address whose two low bits are not zero.
- R11: Accesses to 0x000–0x3FF complete without error and read as 0. Writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Transfer select |
| penable | input | 1 | Access phase of a transfer |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | Error for an unmapped access |
| irq_ovf | output | 1 | Sticky semaphore overflow interrupt |
| timestamp | output | TS_W | Free-running timestamp |

## Verification
The bench builds the bank with NUM_SEM set to 16 and HAS_CNTR_WIN set to 1. The small array puts index 16 inside the window address range while it is still out of range. A write there would alias onto semaphore 0 if the index were truncated, so the bench checks semaphore 0 afterwards. The enabled window also lets the bench test the add-data path, including a saturating sum. With these values the overflow, floor, alias and unmapped cases all fit in a few hundred cycles.

// File: rtl/sem_bank_pkg.sv
package sem_bank_pkg;

  localparam int unsigned DW     = 32;
  localparam int unsigned SLOT_W = 8;     // 0x400-byte window / 4 bytes per slot

  // Address map: the semaphore windows must sit 0x400 apart because the
  // decoder selects them by address bits [ADDR_W-1:10].
  localparam int unsigned OFF_TSINC = 'h0800;
  localparam int unsigned OFF_IRQ   = 'h0804;
  localparam int unsigned WIN_READ  = 'h1000;
  localparam int unsigned WIN_SET   = 'h1400;
  localparam int unsigned WIN_INC   = 'h1800;
  localparam int unsigned WIN_DEC   = 'h1C00;
  localparam int unsigned WIN_CADD  = 'h2000;

  typedef enum logic [3:0] {
    RG_UNMAP,
    RG_EVT,
    RG_TSINC,
    RG_IRQ,
    RG_SREAD,
    RG_SSET,
    RG_SINC,
    RG_SDEC,
    RG_SCADD
  } sem_region_e;

  // Saturating add: the top bit flags that the true sum did not fit.
  function automatic logic [DW:0] sat_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW:0] sum;
    sum = {1'b0, a} + {1'b0, b};
    if (sum[DW]) return {1'b1, {DW{1'b1}}};
    return {1'b0, sum[DW-1:0]};
  endfunction

  // Decrement that stops at zero.
  function automatic logic [DW-1:0] floor_dec(input logic [DW-1:0] a);
    return (a == '0) ? '0 : a - 1'b1;
  endfunction

endpackage

// File: rtl/sem_bank_decode.sv
module sem_bank_decode
  import sem_bank_pkg::*;
#(
  parameter int unsigned NUM_SEM      = 256,
  parameter bit          HAS_CNTR_WIN = 1'b0,
  parameter int unsigned ADDR_W       = 14
) (
  input  logic [ADDR_W-1:0] addr,
  output sem_region_e       region,
  output logic [SLOT_W-1:0] slot,
  output logic              mapped
);
  localparam int unsigned PG_W = ADDR_W - 10;
  localparam int unsigned WD_W = ADDR_W - 2;

  logic [PG_W-1:0] page;
  logic [WD_W-1:0] word;
  logic            aligned;
  logic            slot_ok;

  assign page    = addr[ADDR_W-1:10];
  assign word    = addr[ADDR_W-1:2];
  assign slot    = addr[9:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign slot_ok = ({1'b0, slot} < (SLOT_W+1)'(NUM_SEM));

  always_comb begin
    region = RG_UNMAP;
    if (aligned) begin
      if (page == PG_W'(0))                          region = RG_EVT;
      else if (word == WD_W'(OFF_TSINC >> 2))        region = RG_TSINC;
      else if (word == WD_W'(OFF_IRQ >> 2))          region = RG_IRQ;
      else if (slot_ok) begin
        if (page == PG_W'(WIN_READ >> 10))           region = RG_SREAD;
        else if (page == PG_W'(WIN_SET >> 10))       region = RG_SSET;
        else if (page == PG_W'(WIN_INC >> 10))       region = RG_SINC;
        else if (page == PG_W'(WIN_DEC >> 10))       region = RG_SDEC;
        else if (HAS_CNTR_WIN && (page == PG_W'(WIN_CADD >> 10)))
                                                     region = RG_SCADD;
      end
    end
  end

  assign mapped = (region != RG_UNMAP);

endmodule

// File: rtl/sem_bank_alu.sv
module sem_bank_alu
  import sem_bank_pkg::*;
(
  input  sem_region_e   region,
  input  logic [DW-1:0] cur,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] nxt,
  output logic          upd,
  output logic          ovf
);
  logic [DW:0] add_one;
  logic [DW:0] add_dat;

  assign add_one = sat_add(cur, DW'(1));
  assign add_dat = sat_add(cur, wdata);

  always_comb begin
    nxt = cur;
    upd = 1'b0;
    ovf = 1'b0;
    unique case (region)
      RG_SSET:  begin nxt = wdata;               upd = 1'b1; end
      RG_SINC:  begin nxt = add_one[DW-1:0];     upd = 1'b1; ovf = add_one[DW]; end
      RG_SDEC:  begin nxt = floor_dec(cur);      upd = 1'b1; end
      RG_SCADD: begin nxt = add_dat[DW-1:0];     upd = 1'b1; ovf = add_dat[DW]; end
      default:  ;
    endcase
  end

endmodule

// File: rtl/sem_bank_tstamp.sv
module sem_bank_tstamp #(
  parameter int unsigned INC_W   = 24,
  parameter int unsigned INC_RST = 'h400,
  parameter int unsigned TS_W    = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_we,
  input  logic [INC_W-1:0] inc_wdata,
  output logic [INC_W-1:0] inc_val,
  output logic [TS_W-1:0]  timestamp
);
  logic [INC_W-1:0] inc_q;
  logic [TS_W-1:0]  ts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_q <= INC_W'(INC_RST);
      ts_q  <= '0;
    end else begin
      ts_q <= ts_q + TS_W'(inc_q);
      if (inc_we) inc_q <= inc_wdata;
    end
  end

  assign inc_val   = inc_q;
  assign timestamp = ts_q;

endmodule

// File: rtl/sem_bank.sv
module sem_bank
  import sem_bank_pkg::*;
#(
  parameter int unsigned NUM_SEM      = 256,
  parameter bit          HAS_CNTR_WIN = 1'b0,
  parameter int unsigned ADDR_W       = 14,
  parameter int unsigned INC_W        = 24,
  parameter int unsigned INC_RST      = 'h400,
  parameter int unsigned TS_W         = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DW-1:0]     pwdata,
  output logic [DW-1:0]     prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              irq_ovf,
  output logic [TS_W-1:0]   timestamp
);
  localparam int unsigned IDX_W = $clog2(NUM_SEM);

  // Named internal events, also used by the bound checker.
  logic              access;
  logic              wr_req;
  sem_region_e       region;
  logic [SLOT_W-1:0] slot;
  logic              mapped;
  logic              sem_hit;
  logic [IDX_W-1:0]  idx;
  logic [DW-1:0]     alu_cur;
  logic [DW-1:0]     alu_nxt;
  logic              alu_upd;
  logic              alu_ovf;
  logic              ovf_evt;
  logic              clr_evt;
  logic              inc_we;
  logic [INC_W-1:0]  inc_val;
  logic              irq_q;
  logic [DW-1:0]     sem_q [NUM_SEM];

  assign access  = psel & penable;
  assign wr_req  = access & pwrite;
  assign idx     = slot[IDX_W-1:0];
  assign sem_hit = region inside {RG_SREAD, RG_SSET, RG_SINC, RG_SDEC, RG_SCADD};
  assign alu_cur = sem_q[idx];

  sem_bank_decode #(
    .NUM_SEM      (NUM_SEM),
    .HAS_CNTR_WIN (HAS_CNTR_WIN),
    .ADDR_W       (ADDR_W)
  ) u_decode (
    .addr   (paddr),
    .region (region),
    .slot   (slot),
    .mapped (mapped)
  );

  sem_bank_alu u_alu (
    .region (region),
    .cur    (alu_cur),
    .wdata  (pwdata),
    .nxt    (alu_nxt),
    .upd    (alu_upd),
    .ovf    (alu_ovf)
  );

  assign ovf_evt = wr_req & sem_hit & alu_ovf;
  assign clr_evt = wr_req & (region == RG_IRQ) & pwdata[0];
  assign inc_we  = wr_req & (region == RG_TSINC);

  sem_bank_tstamp #(
    .INC_W   (INC_W),
    .INC_RST (INC_RST),
    .TS_W    (TS_W)
  ) u_tstamp (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc_we    (inc_we),
    .inc_wdata (pwdata[INC_W-1:0]),
    .inc_val   (inc_val),
    .timestamp (timestamp)
  );

  // Semaphore storage: one read-modify-write per access cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SEM; i++) sem_q[i] <= '0;
    end else if (wr_req && sem_hit && alu_upd) begin
      sem_q[idx] <= alu_nxt;
    end
  end

  // Sticky overflow flag; a new overflow takes priority over a clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (ovf_evt) irq_q <= 1'b1;
    else if (clr_evt) irq_q <= 1'b0;
  end

  always_comb begin
    prdata = '0;
    if (access) begin
      unique case (region)
        RG_TSINC:                                     prdata = DW'(inc_val);
        RG_IRQ:                                       prdata = DW'(irq_q);
        RG_SREAD, RG_SSET, RG_SINC, RG_SDEC, RG_SCADD: prdata = alu_cur;
        default:                                      prdata = '0;
      endcase
    end
  end

  assign pready  = 1'b1;
  assign pslverr = access & ~mapped;
  assign irq_ovf = irq_q;

endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk
  import sem_bank_pkg::*;
#(
  parameter int unsigned INC_W = 24,
  parameter int unsigned TS_W  = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             access,
  input logic             pwrite,
  input logic             pslverr,
  input logic [DW-1:0]    prdata,
  input logic             irq_ovf,
  input logic [TS_W-1:0]  timestamp,
  input logic [INC_W-1:0] inc_val,
  input logic             ovf_evt,
  input logic             clr_evt,
  input logic             mapped,
  input sem_region_e      region,
  input logic [DW-1:0]    alu_cur,
  input logic [DW-1:0]    alu_nxt
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_ovf_raises_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> irq_ovf);

  p_irq_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ovf && !clr_evt) |=> irq_ovf);

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_ovf) |-> $past(ovf_evt));

  p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !ovf_evt) |=> !irq_ovf);

  p_dec_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (access && pwrite && region == RG_SDEC && alu_cur == '0) |-> (alu_nxt == '0 && !ovf_evt));

  p_unmapped_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !mapped) |-> (pslverr && prdata == '0));

  p_event_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (access && region == RG_EVT) |-> (!pslverr && prdata == '0));

  p_ts_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (timestamp == $past(timestamp) + TS_W'($past(inc_val))));

endmodule

bind sem_bank sem_bank_chk #(
  .INC_W (INC_W),
  .TS_W  (TS_W)
) i_sem_bank_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .access    (access),
  .pwrite    (pwrite),
  .pslverr   (pslverr),
  .prdata    (prdata),
  .irq_ovf   (irq_ovf),
  .timestamp (timestamp),
  .inc_val   (inc_val),
  .ovf_evt   (ovf_evt),
  .clr_evt   (clr_evt),
  .mapped    (mapped),
  .region    (region),
  .alu_cur   (alu_cur),
  .alu_nxt   (alu_nxt)
);

// File: tb/test_sem_bank.sv
module test_sem_bank;
  localparam int NS = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        psel, penable, pwrite;
  logic [13:0] paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic        pready, pslverr, irq_ovf;
  logic [63:0] timestamp;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  sem_bank #(
    .NUM_SEM      (NS),
    .HAS_CNTR_WIN (1'b1),
    .ADDR_W       (14),
    .INC_W        (24),
    .INC_RST      ('h400),
    .TS_W         (64)
  ) i_sem_bank (
    .clk, .rst_n, .psel, .penable, .pwrite, .paddr, .pwdata,
    .prdata, .pready, .pslverr, .irq_ovf, .timestamp
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [13:0] sa(input int base, input int n);
    return 14'(base + 4 * n);
  endfunction

  // One setup cycle and one access cycle; returns at a falling edge.
  task automatic xfer(input logic wr, input logic [13:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output logic err);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    #1;
    rd  = prdata;
    err = pslverr;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic wr32(input logic [13:0] a, input logic [31:0] d, output logic err);
    logic [31:0] rd;
    xfer(1'b1, a, d, rd, err);
  endtask

  task automatic rd32(input logic [13:0] a, output logic [31:0] rd, output logic err);
    xfer(1'b0, a, 32'h0, rd, err);
  endtask

  task automatic t_reset();
    logic [31:0] v; logic e;
    rd32(sa('h1000, 0), v, e);       chk("R1 sem0", v, 0);
    rd32(sa('h1000, NS-1), v, e);    chk("R1 sem last", v, 0);
    rd32(14'h800, v, e);             chk("R1 step reg", v, 32'h400);
    rd32(14'h804, v, e);             chk("R1 status reg", v, 0);
    chk("R1 irq", irq_ovf, 0);
  endtask

  task automatic t_set_read();
    logic [31:0] v; logic e;
    wr32(sa('h1400, 3), 32'hA5A5_1234, e);
    rd32(sa('h1000, 3), v, e);       chk("R2 set/read", v, 32'hA5A5_1234);
    chk("R2 no err", e, 0);
    rd32(sa('h1800, 3), v, e);       chk("R5 read via inc win", v, 32'hA5A5_1234);
    rd32(sa('h1C00, 3), v, e);       chk("R5 read via dec win", v, 32'hA5A5_1234);
    rd32(sa('h2000, 3), v, e);       chk("R5 read via add win", v, 32'hA5A5_1234);
    wr32(sa('h1000, 3), 32'h0, e);
    rd32(sa('h1000, 3), v, e);       chk("R5 read-window write ignored", v, 32'hA5A5_1234);
  endtask

  task automatic t_inc_b2b();
    logic [31:0] v; logic e;
    wr32(sa('h1400, 4), 32'd10, e);
    wr32(sa('h1800, 4), 32'h0000_FFFF, e);
    wr32(sa('h1800, 4), 32'h1234_0000, e);
    wr32(sa('h1800, 4), 32'h0, e);
    rd32(sa('h1000, 4), v, e);       chk("R7 back-to-back incs", v, 32'd13);
    chk("R3 no ovf", irq_ovf, 0);
    chk("R7 pready", pready, 1);
  endtask

  task automatic t_dec_floor();
    logic [31:0] v; logic e;
    wr32(sa('h1400, 5), 32'd2, e);
    wr32(sa('h1C00, 5), 32'hFFFF_FFFF, e);
    rd32(sa('h1000, 5), v, e);       chk("R4 dec data ignored", v, 32'd1);
    wr32(sa('h1C00, 5), 32'h0, e);
    wr32(sa('h1C00, 5), 32'h0, e);
    rd32(sa('h1000, 5), v, e);       chk("R4 floor at 0", v, 32'd0);
    chk("R4 no irq", irq_ovf, 0);
  endtask

  task automatic t_overflow();
    logic [31:0] v; logic e;
    wr32(sa('h1400, 6), 32'hFFFF_FFFE, e);
    wr32(sa('h1800, 6), 32'h0, e);
    chk("R3 reach max no irq", irq_ovf, 0);
    wr32(sa('h1800, 6), 32'h0, e);
    rd32(sa('h1000, 6), v, e);       chk("R3 saturate", v, 32'hFFFF_FFFF);
    chk("R3 irq set", irq_ovf, 1);
    wr32(sa('h1C00, 6), 32'h0, e);
    chk("R3 irq sticky", irq_ovf, 1);
    rd32(14'h804, v, e);             chk("R8 status mirrors", v, 1);
    wr32(14'h804, 32'hFFFF_FFFE, e); chk("R8 write 0 keeps", irq_ovf, 1);
    wr32(14'h804, 32'h1, e);         chk("R8 write 1 clears", irq_ovf, 0);
  endtask

  task automatic t_cadd();
    logic [31:0] v; logic e;
    wr32(sa('h1400, 7), 32'd100, e);
    wr32(sa('h2000, 7), 32'd25, e);
    rd32(sa('h1000, 7), v, e);       chk("R6 add data", v, 32'd125);
    chk("R6 no err", e, 0);
    wr32(sa('h2000, 7), 32'hFFFF_FFF0, e);
    rd32(sa('h1000, 7), v, e);       chk("R6 saturate", v, 32'hFFFF_FFFF);
    chk("R6 irq", irq_ovf, 1);
    wr32(14'h804, 32'h1, e);
  endtask

  task automatic t_unmapped();
    logic [31:0] v; logic e;
    rd32(sa('h1000, NS), v, e);      chk("R10 idx>=N read", v, 0); chk("R10 idx>=N err", e, 1);
    wr32(sa('h1400, NS), 32'hDEAD_BEEF, e); chk("R10 idx>=N write err", e, 1);
    rd32(sa('h1000, 0), v, e);       chk("R10 sem0 untouched", v, 0);
    rd32(14'h0900, v, e);            chk("R10 hole err", e, 1);
    rd32(14'h2400, v, e);            chk("R10 above err", e, 1);
    rd32(sa('h1000, 3) + 14'd1, v, e); chk("R10 misaligned err", e, 1); chk("R10 misaligned data", v, 0);
  endtask

  task automatic t_event();
    logic [31:0] v; logic e;
    wr32(14'h0010, 32'h5555_AAAA, e); chk("R11 write no err", e, 0);
    rd32(14'h0010, v, e);            chk("R11 reads 0", v, 0); chk("R11 read no err", e, 0);
  endtask

  task automatic t_tstamp();
    logic [31:0] v; logic e; logic [63:0] a, b;
    a = timestamp; @(negedge clk); b = timestamp;
    chk("R9 default step", b - a, 64'h400);
    wr32(14'h800, 32'hFF00_0007, e);
    rd32(14'h800, v, e);             chk("R9 step width", v, 32'h7);
    a = timestamp; @(negedge clk); b = timestamp;
    chk("R9 new step", b - a, 64'h7);
  endtask

  initial begin
    rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 timestamp", timestamp, 0);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_read();
    t_inc_b2b();
    t_dec_floor();
    t_overflow();
    t_cadd();
    t_unmapped();
    t_event();
    t_tstamp();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule